// File: doc/BRIEF.md
# Condition-Code Arithmetic Unit

This block is the arithmetic and logic stage of a small CPU datapath. Each issued operation takes a destination operand, a source operand, an operation code and a size code that selects an 8-, 16- or 32-bit lane. One clock later the block presents the truncated result with a write-enable pulse. In the same cycle it updates four condition flags (negative, zero, overflow, carry). Each class of operation has its own rule for updating the flags.

The flags live in a four-bit register that reads out as a packed byte. A separate write port loads that register in one cycle, so that control code can save and restore it. Instruction decode, the register file and memory access sit outside this block. The block only sees operand values and returns a result together with a write strobe.

Top module: `ccr_alu`

## Requirements
- R1: `flag_byte` holds C in bit 0, V in bit 1, Z in bit 2 and N in bit 3, and its bits 7:4 always read as zero. After reset all eight bits are zero.
- R2: When `flag_wr` is high at a clock edge, bits 3:0 of `flag_din` are loaded into the flag register. An operation issued at that same edge is discarded: `res_we` stays low, `res_out` holds its value and the flags come only from `flag_din`.
- R3: Operation codes: 0 add, 1 subtract, 2 add with carry, 3 subtract with carry, 4 compare, 5 negate, 6 increment, 7 decrement, 8 AND, 9 OR, 10 XOR, 11 move. Subtract, compare and decrement add the two's-complement negation of `src_in`. Negate uses zero as the destination value. Size codes: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operands are taken from the low bits of the selected width, and the result is truncated to that width and zero-extended on `res_out`.
- R4: Add with carry adds `src_in` plus the current C flag. Subtract with carry adds the negation of (`src_in` plus C).
- R5: For operation codes 0 to 5, V is set when the destination value and the addend share a sign bit and the sign bit of the sum differs from it.
- R6: For operation codes 0 to 5 at 8 or 16 bits, C is the bit of the full sum just above the width. At 32 bits, C is set when the unsigned 32-bit result is less than the destination value or less than the 32-bit addend.
- R7: Compare updates all four flags exactly as subtract would, but `res_we` stays low and `res_out` is unchanged.
- R8: Increment adds `src_in` and decrement subtracts it. Both write the result and update N and Z. V is set when every destination bit below the sign bit is one, and C is left unchanged.
- R9: AND, OR, XOR and move (result = `src_in`) write the result, update N and Z, clear V and leave C unchanged.
- R10: For every operation, N is the sign bit of the selected width and Z is set when the truncated result is zero. Bits above the width never affect either flag.
- R11: Operation codes 12 to 15 write nothing and change no flag.
- R12: Results and flags appear in the cycle after the edge that accepts `op_valid`. `res_we` is high for exactly that one cycle for a writing operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 4 | Operation code (R3) |
| op_size | input | 2 | Width select (R3) |
| dst_in | input | 32 | Destination operand |
| src_in | input | 32 | Source operand |
| flag_wr | input | 1 | Load flags from `flag_din` |
| flag_din | input | 8 | Packed flag byte to load |
| res_out | output | 32 | Registered, truncated result |
| res_we | output | 1 | Result write strobe |
| flag_byte | output | 8 | Packed flag register |

## Verification
The sweep concentrates on values that sit on a sign or width boundary: 0x7F, 0x80, 0xFF, 0x7FFF, 0x8000, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, crossed with both states of the incoming carry. These values expose several possible faults. A design that takes carry from bit 32 at full width, or from the wrong bit at 8 bits, reports a wrong C after a wrap. A design that tests the overflow of increment on the result instead of the operand's low bits misses the quirky V. A design that lets bits above the width reach Z or N flags a zero byte result as non-zero.

The bench also targets three behaviours of the flag register. An operation issued alongside a flag write must lose. Compare and the unused codes must leave `res_out` alone. Logic operations must keep the carry they were given.

// File: rtl/ccr_alu_pkg.sv
package ccr_alu_pkg;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_ADDC = 4'd2;
  localparam logic [3:0] OP_SUBC = 4'd3;
  localparam logic [3:0] OP_CMP  = 4'd4;
  localparam logic [3:0] OP_NEG  = 4'd5;
  localparam logic [3:0] OP_INC  = 4'd6;
  localparam logic [3:0] OP_DEC  = 4'd7;
  localparam logic [3:0] OP_AND  = 4'd8;
  localparam logic [3:0] OP_OR   = 4'd9;
  localparam logic [3:0] OP_XOR  = 4'd10;
  localparam logic [3:0] OP_MOV  = 4'd11;

  typedef enum logic [1:0] {
    CLS_ARITH,
    CLS_STEP,
    CLS_LOGIC,
    CLS_NONE
  } op_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/ccr_alu_decode.sv
module ccr_alu_decode
  import ccr_alu_pkg::*;
(
  input  logic [3:0] op,
  output op_class_e  cls,
  output logic       writes
);

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_ADDC, OP_SUBC, OP_CMP, OP_NEG: cls = CLS_ARITH;
      OP_INC, OP_DEC:                                   cls = CLS_STEP;
      OP_AND, OP_OR, OP_XOR, OP_MOV:                    cls = CLS_LOGIC;
      default:                                          cls = CLS_NONE;
    endcase
    writes = (cls != CLS_NONE) && (op != OP_CMP);
  end

endmodule

// File: rtl/ccr_alu_lane.sv
module ccr_alu_lane
  import ccr_alu_pkg::*;
#(
  parameter int LW     = 8,
  parameter int WIDE_W = 32
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic [3:0]    op,
  input  op_class_e     cls,
  input  logic          cin,
  output logic [LW-1:0] res,
  output flags_t        fout
);

  localparam int XW = LW + 2;
  localparam bit UNSIGNED_CARRY = (LW >= WIDE_W);

  logic [XW-1:0] dx, bx, addend, sum;
  logic [LW-1:0] logic_res, sum_w;
  logic          carry_arith, v_arith, v_step;

  always_comb begin
    bx = {2'b00, b};
    dx = {2'b00, a};
    addend = bx;
    unique case (op)
      OP_ADDC:         addend = bx + XW'(cin);
      OP_SUB, OP_CMP:  addend = -bx;
      OP_SUBC:         addend = -(bx + XW'(cin));
      OP_NEG: begin
        dx     = '0;
        addend = -bx;
      end
      OP_DEC:          addend = -bx;
      default:         addend = bx;
    endcase
    sum   = dx + addend;
    sum_w = sum[LW-1:0];
  end

  generate
    if (UNSIGNED_CARRY) begin : g_cmp_carry
      assign carry_arith = (sum_w < dx[LW-1:0]) || (sum_w < addend[LW-1:0]);
    end else begin : g_bit_carry
      assign carry_arith = sum[LW];
    end
  endgenerate

  assign v_arith = (addend[LW-1] == dx[LW-1]) && (addend[LW-1] != sum[LW-1]);
  assign v_step  = &dx[LW-2:0];

  always_comb begin
    unique case (op)
      OP_AND:  logic_res = a & b;
      OP_OR:   logic_res = a | b;
      OP_XOR:  logic_res = a ^ b;
      default: logic_res = b;
    endcase
  end

  always_comb begin
    res  = (cls == CLS_LOGIC) ? logic_res : sum_w;
    fout.n = res[LW-1];
    fout.z = (res == '0);
    unique case (cls)
      CLS_ARITH: begin
        fout.v = v_arith;
        fout.c = carry_arith;
      end
      CLS_STEP: begin
        fout.v = v_step;
        fout.c = cin;
      end
      default: begin
        fout.v = 1'b0;
        fout.c = cin;
      end
    endcase
  end

endmodule

// File: rtl/ccr_alu.sv
module ccr_alu
  import ccr_alu_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int NLANE  = 3,
  parameter int DATA_W = BASE_W << (NLANE - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [DATA_W-1:0] src_in,
  input  logic              flag_wr,
  input  logic [7:0]        flag_din,
  output logic [DATA_W-1:0] res_out,
  output logic              res_we,
  output logic [7:0]        flag_byte
);

  op_class_e         cls;
  logic              writes;
  flags_t            flags_q;
  logic [DATA_W-1:0] lane_res [NLANE];
  flags_t            lane_flags [NLANE];
  logic [DATA_W-1:0] sel_res;
  flags_t            sel_flags;
  int                sel_idx;

  ccr_alu_decode u_dec (
    .op     (op_code),
    .cls    (cls),
    .writes (writes)
  );

  generate
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
      localparam int LW = BASE_W << i;
      logic [LW-1:0] r;
      ccr_alu_lane #(.LW(LW), .WIDE_W(DATA_W)) u_lane (
        .a    (dst_in[LW-1:0]),
        .b    (src_in[LW-1:0]),
        .op   (op_code),
        .cls  (cls),
        .cin  (flags_q.c),
        .res  (r),
        .fout (lane_flags[i])
      );
      assign lane_res[i] = DATA_W'(r);
    end
  endgenerate

  always_comb begin
    sel_idx   = (int'(op_size) >= NLANE) ? NLANE - 1 : int'(op_size);
    sel_res   = lane_res[sel_idx];
    sel_flags = lane_flags[sel_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      res_out <= '0;
      res_we  <= 1'b0;
    end else if (flag_wr) begin
      flags_q <= flags_t'(flag_din[3:0]);
      res_we  <= 1'b0;
    end else if (op_valid && cls != CLS_NONE) begin
      flags_q <= sel_flags;
      res_we  <= writes;
      if (writes) res_out <= sel_res;
    end else begin
      res_we <= 1'b0;
    end
  end

  assign flag_byte = {4'b0000, flags_q};

endmodule

// File: rtl/ccr_alu_chk.sv
module ccr_alu_chk
  import ccr_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [1:0]        op_size,
  input logic              flag_wr,
  input logic [7:0]        flag_din,
  input logic [DATA_W-1:0] res_out,
  input logic              res_we,
  input logic [7:0]        flag_byte
);

  logic issue;
  assign issue = op_valid && !flag_wr;

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    flag_byte[7:4] == 4'b0000);

  a_r2_flag_load: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> (flag_byte[3:0] == $past(flag_din[3:0])) && !res_we);

  a_r3_narrow_result: assert property (@(posedge clk) disable iff (rst)
    issue && op_size == 2'd0 && op_code != OP_CMP && op_code < 4'd12
    |=> res_out[DATA_W-1:8] == '0);

  a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    issue && op_code == OP_CMP |=> !res_we && $stable(res_out));

  a_r8_step_keeps_c: assert property (@(posedge clk) disable iff (rst)
    issue && (op_code == OP_INC || op_code == OP_DEC)
    |=> flag_byte[0] == $past(flag_byte[0]));

  a_r9_logic_v_clear: assert property (@(posedge clk) disable iff (rst)
    issue && op_code >= OP_AND && op_code <= OP_MOV
    |=> !flag_byte[1] && flag_byte[0] == $past(flag_byte[0]));

  a_r10_zero_matches: assert property (@(posedge clk) disable iff (rst)
    res_we |-> flag_byte[2] == (res_out == '0));

  a_r11_bad_op_idle: assert property (@(posedge clk) disable iff (rst)
    issue && op_code >= 4'd12 |=> !res_we && $stable(flag_byte) && $stable(res_out));

  a_r12_we_source: assert property (@(posedge clk) disable iff (rst)
    res_we |-> $past(op_valid) && !$past(flag_wr));

endmodule

bind ccr_alu ccr_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ccr_alu_tb.sv
module ccr_alu_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [1:0]  op_size;
  logic [31:0] dst_in, src_in;
  logic        flag_wr;
  logic [7:0]  flag_din;
  logic [31:0] res_out;
  logic        res_we;
  logic [7:0]  flag_byte;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  longint prev_res = 0;

  localparam longint VALS [12] = '{64'h0, 64'h1, 64'h7F, 64'h80, 64'hFF, 64'h7FFF,
                                   64'h8000, 64'hFFFF, 64'h7FFFFFFF, 64'h80000000,
                                   64'hFFFFFFFF, 64'h12345678};

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_alu u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_size(op_size),
    .dst_in(dst_in), .src_in(src_in), .flag_wr(flag_wr), .flag_din(flag_din),
    .res_out(res_out), .res_we(res_we), .flag_byte(flag_byte)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference computed from the requirement text
  task automatic model(input int op, input int sz, input longint d, input longint s,
                       input logic [3:0] f, output longint r, output bit we,
                       output logic [3:0] nf);
    int w;
    longint mask, dm, sm, ea, rdv, sum, rm;
    bit n, z, v, c;
    w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (longint'(1) << w) - 1;
    dm = d & mask;
    sm = s & mask;
    rdv = dm;
    ea  = sm;
    c   = f[0];
    v   = 1'b0;
    rm  = 0;
    we  = (op < 12) && (op != 4);
    if (op >= 12) begin
      nf = f;
      r  = 0;
      return;
    end
    case (op)
      2: ea = sm + f[0];
      1, 4, 7: ea = -sm;
      3: ea = -(sm + f[0]);
      5: begin rdv = 0; ea = -sm; end
      default: ea = sm;
    endcase
    sum = rdv + ea;
    if (op <= 7) rm = sum & mask;
    else case (op)
      8: rm = dm & sm;
      9: rm = dm | sm;
      10: rm = dm ^ sm;
      default: rm = sm;
    endcase
    n = ((rm >> (w-1)) & 1) != 0;
    z = (rm == 0);
    if (op <= 5) begin
      v = (((ea >>> (w-1)) & 1) == ((rdv >>> (w-1)) & 1)) &&
          (((ea >>> (w-1)) & 1) != ((sum >>> (w-1)) & 1));
      if (w < 32) c = ((sum >>> w) & 1) != 0;
      else        c = (rm < rdv) || (rm < (ea & mask));
    end else if (op <= 7) begin
      v = (rdv & (mask >> 1)) == (mask >> 1);
    end
    r  = rm;
    nf = {n, z, v, c};
  endtask

  task automatic load_flags(input logic [3:0] f);
    @(negedge clk);
    flag_wr  = 1'b1;
    flag_din = {4'b1010, f};
    @(negedge clk);
    flag_wr = 1'b0;
    check(flag_byte == {4'b0, f}, "R2 load", flag_byte, {4'b0, f});
  endtask

  task automatic run_vec(input int op, input int sz, input longint d, input longint s,
                         input logic [3:0] f);
    longint er;
    bit ewe;
    logic [3:0] ef;
    string tag_r, tag_v, tag_c;
    load_flags(f);
    model(op, sz, d, s, f, er, ewe, ef);
    op_valid = 1'b1;
    op_code  = 4'(op);
    op_size  = 2'(sz);
    dst_in   = d[31:0];
    src_in   = s[31:0];
    @(negedge clk);
    op_valid = 1'b0;
    tag_r = (op == 2 || op == 3) ? "R4 result" : (op == 4) ? "R7 result" :
            (op == 6 || op == 7) ? "R8 result" : (op >= 8 && op < 12) ? "R9 result" :
            (op >= 12) ? "R11 result" : "R3 result";
    tag_v = (op <= 5) ? "R5 V" : (op <= 7) ? "R8 V" : (op < 12) ? "R9 V" : "R11 V";
    tag_c = (op <= 5) ? "R6 C" : (op <= 7) ? "R8 C" : (op < 12) ? "R9 C" : "R11 C";
    if (ewe) prev_res = er;
    check(res_we == ewe, "R12 we", res_we, ewe);
    check(res_out == prev_res[31:0], tag_r, res_out, prev_res);
    check(flag_byte[3:2] == ef[3:2], "R10 NZ", flag_byte[3:2], ef[3:2]);
    check(flag_byte[1] == ef[1], tag_v, flag_byte[1], ef[1]);
    check(flag_byte[0] == ef[0], tag_c, flag_byte[0], ef[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = '0; op_size = '0;
    dst_in = '0; src_in = '0; flag_wr = 1'b0; flag_din = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(flag_byte == 8'h00, "R1 reset flags", flag_byte, 0);
    check(res_we == 1'b0, "R1 reset we", res_we, 0);
    check(res_out == 32'h0, "R1 reset result", res_out, 0);

    // R1: upper bits of flag byte stay zero
    @(negedge clk);
    flag_wr = 1'b1; flag_din = 8'hFF;
    @(negedge clk);
    flag_wr = 1'b0;
    check(flag_byte == 8'h0F, "R1 packing", flag_byte, 8'h0F);

    // R2: flag write wins over a simultaneous operation
    run_vec(0, 2, 64'h11, 64'h22, 4'h0);
    @(negedge clk);
    flag_wr = 1'b1; flag_din = 8'h05;
    op_valid = 1'b1; op_code = 4'd0; op_size = 2'd2; dst_in = 32'h100; src_in = 32'h1;
    @(negedge clk);
    flag_wr = 1'b0; op_valid = 1'b0;
    check(flag_byte == 8'h05, "R2 priority flags", flag_byte, 8'h05);
    check(res_we == 1'b0, "R2 priority we", res_we, 0);
    check(res_out == 32'h33, "R2 priority result", res_out, 32'h33);

    // R12: strobe lasts one cycle
    run_vec(9, 0, 64'h0F, 64'hF0, 4'h0);
    @(negedge clk);
    check(res_we == 1'b0, "R12 pulse", res_we, 0);

    // R3: size code 3 behaves as 32 bits
    run_vec(0, 3, 64'hFFFFFFFF, 64'h2, 4'h0);
    run_vec(1, 3, 64'h0, 64'h1, 4'h0);

    // sweep all operations and sizes over boundary operands
    for (int op = 0; op < 16; op++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int i = 0; i < 12; i++) begin
          for (int j = 0; j < 12; j++) begin
            for (int cin = 0; cin < 2; cin++) begin
              run_vec(op, sz, VALS[i], VALS[j], {2'(i ^ j), 1'((i + j) & 1), 1'(cin)});
            end
          end
          if (op >= 12) break;
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule